// File: doc/BRIEF.md
# Masked Priority Interrupt Encoder

This block gathers sixteen level-sensitive interrupt lines from a local peripheral bus into a source register. Each source bit copies the level of its line on every clock. A programmable enable mask gates the source register. The lines that survive the mask are the pending set. A single combined interrupt output tells the processor that at least one enabled line is active.

Software reads the pending set through a small 16-bit register window. One offset returns a vector that encodes the lowest-numbered pending line. The encoding never gives zero for a real request, so the handler can use the value directly as a table index. The other offset holds the enable mask and can be both read and written.

The mask comes out of reset with only line 4 enabled. Everything the block presents is derived from registered state. A change on a line or in the mask therefore appears at the output one clock later.

Top module: `lbirq_encoder`

## Requirements
- R1: Source bit i copies interrupt line i at each rising clock edge. A line that rises or falls is visible in the source register, and in everything derived from it, one clock later.
- R2: The pending set is the source register ANDed bitwise with the enable mask. `irq_out` is high exactly when the pending set is nonzero.
- R3: A read at byte offset 0x0 returns 4*(i+1) on `reg_rdata`, where i is the lowest-numbered pending line. Line 0 gives 0x0004 and line 15 gives 0x0040.
- R4: A read at offset 0x0 returns 0x0000 when nothing is pending, including the case where lines are high but masked off.
- R5: Offset 0x2 holds the 16-bit enable mask, where bit i enables line i. A write there is stored at the clock edge and takes effect on `irq_out` and on the vector from the next cycle. A read there returns the stored mask.
- R6: After reset the mask reads 0x0010, the source register is all zero, `irq_out` is low and the vector reads 0x0000.
- R7: A read at any offset other than 0x0 and 0x2 returns 0x0000. This applies to odd offsets as well. A write to any such offset leaves the mask unchanged.
- R8: Offset 0x0 is read-only. A write there leaves the mask and the vector unchanged.
- R9: When several lines are pending, the lowest-numbered one sets the vector, whatever the higher lines do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | 16 | Level-sensitive interrupt request lines |
| reg_addr | input | 4 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational from registered state |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench raises every line alone, then every mask bit alone against all lines high. A design with an off-by-one in the vector encoding, or one that favours the highest line, produces a wrong vector in one of these sweeps. The case with lines high but all masked off catches a design that forgets the mask or reports a nonzero vector when nothing is pending. Pseudo-random line and mask pairs check priority among several pending lines. Timing probes sample before and after the capturing edge, so an output that is combinational from the inputs, or one a cycle late, is exposed. Writes to the read-only offset and to undefined offsets must leave the mask intact, which catches decoding that ignores some address bits.

// File: rtl/lbirq_pkg.sv
package lbirq_pkg;
  // Vector value reported for pending line idx: never zero for a real request.
  function automatic int unsigned vec_code(input int unsigned idx);
    return (idx + 1) << 2;
  endfunction

  // Byte offsets decoded by the register window.
  localparam int unsigned OFF_VECTOR = 0;
  localparam int unsigned OFF_ENABLE = 2;
endpackage

// File: rtl/lbirq_src_capture.sv
module lbirq_src_capture #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  output logic [N-1:0] src
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src <= '0;
    else        src <= lines;
  end

  a_r1_src_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> src == $past(lines));
endmodule

// File: rtl/lbirq_mask_reg.sv
module lbirq_mask_reg #(
  parameter int          N      = 16,
  parameter int          AW     = 4,
  parameter int unsigned OFFSET = 2,
  parameter logic [N-1:0] RESET_VAL = 16'h0010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [N-1:0]  wdata,
  output logic [N-1:0]  mask
);
  logic hit_wr;
  assign hit_wr = wr && (addr == AW'(OFFSET));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask <= RESET_VAL;
    else if (hit_wr) mask <= wdata;
  end

  a_r5_mask_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == AW'(OFFSET)) |=> mask == $past(wdata));
  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == AW'(OFFSET)) |=> $stable(mask));
endmodule

// File: rtl/lbirq_prio_enc.sv
module lbirq_prio_enc
  import lbirq_pkg::*;
#(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend,
  output logic [N-1:0] grant,
  output logic [W-1:0] code
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1] = seen[i] | pend[i];
    assign grant[i]  = pend[i] & ~seen[i];
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) code = code | W'(vec_code(i));
    end
  end

  a_r9_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r4_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (code == '0));
  a_r3_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |-> ((grant & pend) != '0));
endmodule

// File: rtl/lbirq_rdmux.sv
module lbirq_rdmux
  import lbirq_pkg::*;
#(
  parameter int N  = 16,
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  code,
  input  logic [N-1:0]  mask,
  output logic [W-1:0]  rdata
);
  always_comb begin
    if (addr == AW'(OFF_VECTOR))      rdata = code;
    else if (addr == AW'(OFF_ENABLE)) rdata = W'(mask);
    else                              rdata = '0;
  end
endmodule

// File: rtl/lbirq_encoder.sv
module lbirq_encoder
  import lbirq_pkg::*;
#(
  parameter int           NUM_LINES = 16,
  parameter int           DATA_W    = 16,
  parameter int           ADDR_W    = 4,
  parameter logic [15:0]  MASK_INIT = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       irq_lines,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              irq_out
);
  localparam int N = NUM_LINES;
  localparam int W = DATA_W;

  logic [N-1:0] src;
  logic [N-1:0] mask;
  logic [N-1:0] pending;
  logic [N-1:0] grant;
  logic [W-1:0] code;

  lbirq_src_capture #(.N(N)) u_src (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines), .src(src)
  );

  lbirq_mask_reg #(.N(N), .AW(ADDR_W), .OFFSET(OFF_ENABLE), .RESET_VAL(MASK_INIT)) u_mask (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
    .wdata(reg_wdata), .mask(mask)
  );

  assign pending = src & mask;

  lbirq_prio_enc #(.N(N), .W(W)) u_enc (
    .clk(clk), .rst_n(rst_n), .pend(pending), .grant(grant), .code(code)
  );

  lbirq_rdmux #(.N(N), .W(W), .AW(ADDR_W)) u_rd (
    .addr(reg_addr), .code(code), .mask(mask), .rdata(reg_rdata)
  );

  assign irq_out = |pending;

  a_r2_out_matches_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (code != '0));
  a_r2_out_matches_grant: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (grant != '0));
endmodule

// File: tb/tb_lbirq_encoder.sv
module tb_lbirq_encoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_lines = '0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;  // 50 MHz

  lbirq_encoder dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic int expect_vec(input logic [15:0] lines, input logic [15:0] m);
    logic [15:0] p = lines & m;
    for (int i = 0; i < 16; i++) if (p[i]) return 4 * i + 4;
    return 0;
  endfunction

  task automatic read_at(input logic [3:0] a, output int v);
    reg_addr = a;
    #2;
    v = int'(reg_rdata);
  endtask

  task automatic write_at(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic drive_lines(input logic [15:0] l);
    @(negedge clk);
    irq_lines = l;
    @(negedge clk);
  endtask

  initial begin
    int v;
    logic [15:0] cur_mask;
    logic [31:0] lfsr = 32'hACE1_1234;
    logic [15:0] rl, rm;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 reset state
    read_at(4'h2, v); check("R6 mask reset", v, 16'h0010);
    read_at(4'h0, v); check("R6 vector reset", v, 0);
    check("R6 irq reset", int'(irq_out), 0);

    // R1/R2 timing: line 4 enabled by reset mask
    @(negedge clk);
    irq_lines = 16'h0010;
    #2; check("R1 no change before edge", int'(irq_out), 0);
    @(negedge clk);
    check("R1 irq after one edge", int'(irq_out), 1);
    read_at(4'h0, v); check("R3 line4 vector", v, 20);
    irq_lines = 16'h0000;
    #2; check("R1 still high before edge", int'(irq_out), 1);
    @(negedge clk);
    check("R1 irq falls after edge", int'(irq_out), 0);

    // R5 mask write
    write_at(4'h2, 16'hFFFF);
    read_at(4'h2, v); check("R5 mask readback", v, 16'hFFFF);
    cur_mask = 16'hFFFF;

    // R3/R9 single-line sweep
    for (int i = 0; i < 16; i++) begin
      drive_lines(16'(1 << i));
      read_at(4'h0, v); check("R3 single line vector", v, 4 * (i + 1));
      check("R2 single line irq", int'(irq_out), 1);
    end

    // R9: all lines high, each mask bit alone; R4: line masked off
    for (int k = 0; k < 16; k++) begin
      write_at(4'h2, 16'(1 << k));
      drive_lines(16'hFFFF);
      read_at(4'h0, v); check("R9 mask-select vector", v, 4 * k + 4);
      drive_lines(~16'(1 << k));
      read_at(4'h0, v); check("R4 masked vector zero", v, 0);
      check("R4 masked irq low", int'(irq_out), 0);
    end

    // R5 mask change visible on next cycle with lines steady
    drive_lines(16'h0100);
    check("R5 irq low before enable", int'(irq_out), 0);
    write_at(4'h2, 16'h0100);
    check("R5 irq after mask write", int'(irq_out), 1);
    read_at(4'h0, v); check("R5 vector after mask write", v, 36);
    cur_mask = 16'h0100;

    // R8 write to vector offset ignored
    write_at(4'h0, 16'h0000);
    read_at(4'h2, v); check("R8 mask kept", v, 16'h0100);
    read_at(4'h0, v); check("R8 vector kept", v, 36);

    // R7 undefined offsets: reads zero, writes ignored
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 2) begin
        write_at(4'(a), 16'h0000);
        read_at(4'(a), v); check("R7 undefined read zero", v, 0);
      end
    end
    read_at(4'h2, v); check("R7 mask unchanged", v, 16'h0100);
    check("R7 irq unchanged", int'(irq_out), 1);

    // R2/R3/R9 pseudo-random sweep
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rl = lfsr[15:0] & lfsr[31:16];
      rm = lfsr[23:8];
      write_at(4'h2, rm);
      drive_lines(rl);
      read_at(4'h0, v); check("R9 random vector", v, expect_vec(rl, rm));
      check("R2 random irq", int'(irq_out), ((rl & rm) != 0) ? 1 : 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule